// File: doc/BRIEF.md
# Word-Interleaved Banked Scratchpad Crossbar

This block is the switch between eight requesters and a shared 16 kB data scratchpad. Four ports face processor cores and four face a DMA engine. All eight see the same storage and follow the same rules. The storage is split into eight single-port banks of 2 kB each. Consecutive 32-bit words fall into consecutive banks, so linear streams spread evenly over all of them.

Every port drives a request with an address, a write flag, byte strobes and write data. The grant comes back in the same cycle. Each bank has its own round-robin arbiter. Requests that land in different banks are all served in parallel. When two or more ports hit one bank, the arbiter picks one of them and the others wait. A waiting port keeps its request unchanged until it is granted. Read data returns on the following cycle, marked by a valid flag, and goes only to the port that issued the read.

Top module: `spm_xbar`

## Requirements
- R1: A byte address splits as follows. Bits [1:0] are ignored. Bits [4:2] select the bank. Bits [13:5] select the word inside the bank. Addresses 4k and 4k+4 therefore fall in different banks, and addresses 32 bytes apart fall in the same bank.
- R2: In one cycle, requests that all target different banks are all granted in that cycle.
- R3: A bank grants at most one port per cycle. A grant only goes to a port that is requesting. A port that is not granted gets neither a grant nor a read-valid for that request.
- R4: Each bank uses round robin. After a grant, the search for the next grant starts at the port index just after the last winner, wrapping from 7 to 0. After reset the search starts at port 0.
- R5: For a granted read, rvalid and the word stored at the addressed location appear on the issuing port exactly one cycle after the grant cycle. Nothing appears on any other port.
- R6: Byte strobe bit i enables write data bits [8i+7:8i]. Bytes whose strobe is low keep their old value.
- R7: A granted write never produces a read-valid.
- R8: While reset is high and on the cycle after it, no read-valid is raised. With no request, no grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Request per port (ports 0-3 core, 4-7 DMA) |
| addr_i | input | 112 | 14-bit byte address per port, port m at [14m+13:14m] |
| we_i | input | 8 | Write flag per port |
| be_i | input | 32 | 4-bit byte strobes per port |
| wdata_i | input | 256 | 32-bit write data per port |
| gnt_o | output | 8 | Same-cycle grant per port |
| rvalid_o | output | 8 | Read data valid, one cycle after a read grant |
| rdata_o | output | 256 | 32-bit read data per port |

## Verification
Two things can happen in the same cycle: several banks each serve a different port, and one bank resolves a conflict while the other banks keep working. The bench provokes both. In one cycle it places all eight ports on eight distinct banks. It also stacks all eight ports on a single bank after a known last winner, so the expected grant order is fixed in advance. A per-cycle monitor recomputes from the presented addresses how many grants each bank should give. A scoreboard matches every returned word against a byte-accurate model and checks its arrival cycle.

// File: rtl/spm_pkg.sv
`timescale 1ns/1ps
package spm_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam int OFS_W  = $clog2(STRB_W);
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [STRB_W-1:0] strb_t;
endpackage

// File: rtl/spm_rr_arb.sv
`timescale 1ns/1ps
module spm_rr_arb #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] win_idx,
  output logic          any
);
  logic [IW-1:0] ptr_q;
  logic          live_q;

  always_comb begin
    gnt     = '0;
    win_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!any && req[idx]) begin
        any      = 1'b1;
        win_idx  = IW'(idx);
        gnt[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (any) ptr_q <= (win_idx == IW'(N-1)) ? '0 : win_idx + IW'(1);
    end
  end

  // R3
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  // R3
  gnt_subset_chk: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0);
  // R2
  busy_grant_chk: assert property (@(posedge clk) disable iff (rst) (|req) |-> (|gnt));
  // R4: a port that lost and still waits beats the previous winner
  no_repeat_win_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && (|$past(gnt)) && (($past(req) & ~$past(gnt) & req) != '0))
      |-> ((gnt & $past(gnt)) == '0));
endmodule

// File: rtl/spm_bank.sv
`timescale 1ns/1ps
module spm_bank
  import spm_pkg::*;
#(
  parameter int WORDS = 512,
  localparam int ROW_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  strb_t            be,
  input  logic [ROW_W-1:0] row,
  input  word_t            wdata,
  output word_t            rdata
);
  word_t mem [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int i = 0; i < STRB_W; i++)
          if (be[i]) mem[row][8*i +: 8] <= wdata[8*i +: 8];
      end else begin
        rdata <= mem[row];
      end
    end
  end
endmodule

// File: rtl/spm_xbar.sv
`timescale 1ns/1ps
module spm_xbar
  import spm_pkg::*;
#(
  parameter int N_MST      = 8,
  parameter int N_BANK     = 8,
  parameter int BANK_WORDS = 512,
  localparam int BK_W   = (N_BANK > 1) ? $clog2(N_BANK) : 1,
  localparam int ROW_W  = $clog2(BANK_WORDS),
  localparam int ADDR_W = OFS_W + BK_W + ROW_W,
  localparam int MI_W   = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_MST-1:0]         req_i,
  input  logic [N_MST*ADDR_W-1:0]  addr_i,
  input  logic [N_MST-1:0]         we_i,
  input  logic [N_MST*STRB_W-1:0]  be_i,
  input  logic [N_MST*DATA_W-1:0]  wdata_i,
  output logic [N_MST-1:0]         gnt_o,
  output logic [N_MST-1:0]         rvalid_o,
  output logic [N_MST*DATA_W-1:0]  rdata_o
);
  logic [BK_W-1:0]  m_bank [N_MST];
  logic [ROW_W-1:0] m_row  [N_MST];
  logic [N_MST-1:0] b_gnt  [N_BANK];
  logic [MI_W-1:0]  b_win  [N_BANK];
  logic             b_any  [N_BANK];
  word_t            b_rdata[N_BANK];
  logic [MI_W-1:0]  owner_q[N_BANK];
  logic             rd_q   [N_BANK];

  always_comb begin
    for (int m = 0; m < N_MST; m++) begin
      m_bank[m] = addr_i[m*ADDR_W + OFS_W +: BK_W];
      m_row[m]  = addr_i[m*ADDR_W + OFS_W + BK_W +: ROW_W];
    end
  end

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic [N_MST-1:0] breq;
    logic             bwe;
    strb_t            bbe;
    logic [ROW_W-1:0] brow;
    word_t            bwd;

    always_comb begin
      for (int m = 0; m < N_MST; m++)
        breq[m] = req_i[m] && (m_bank[m] == BK_W'(b));
      bwe  = we_i[b_win[b]];
      bbe  = be_i[int'(b_win[b])*STRB_W +: STRB_W];
      brow = m_row[b_win[b]];
      bwd  = wdata_i[int'(b_win[b])*DATA_W +: DATA_W];
    end

    spm_rr_arb #(.N(N_MST)) u_arb (
      .clk(clk), .rst(rst), .req(breq),
      .gnt(b_gnt[b]), .win_idx(b_win[b]), .any(b_any[b])
    );

    spm_bank #(.WORDS(BANK_WORDS)) u_mem (
      .clk(clk), .en(b_any[b]), .we(bwe), .be(bbe),
      .row(brow), .wdata(bwd), .rdata(b_rdata[b])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_q[b]    <= 1'b0;
        owner_q[b] <= '0;
      end else begin
        rd_q[b]    <= b_any[b] && !bwe;
        owner_q[b] <= b_win[b];
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    for (int b = 0; b < N_BANK; b++) gnt_o = gnt_o | b_gnt[b];
  end

  always_comb begin
    rvalid_o = '0;
    rdata_o  = '0;
    for (int b = 0; b < N_BANK; b++) begin
      if (rd_q[b]) begin
        rvalid_o[owner_q[b]] = 1'b1;
        rdata_o[int'(owner_q[b])*DATA_W +: DATA_W] = b_rdata[b];
      end
    end
  end

  // R8
  rst_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (rvalid_o == '0));

  for (genvar m = 0; m < N_MST; m++) begin : g_chk
    logic [N_BANK-1:0] col;
    always_comb
      for (int b = 0; b < N_BANK; b++) col[b] = b_gnt[b][m];
    // R3
    one_bank_per_port_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(col));
    // R5
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
      rvalid_o[m] |-> $past(gnt_o[m] && !we_i[m]));
    // R7
    write_no_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
      (gnt_o[m] && we_i[m]) |=> !rvalid_o[m]);
  end
endmodule

// File: tb/spm_xbar_tb.sv
`timescale 1ns/1ps
module spm_xbar_tb;
  localparam int NM = 8;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NM-1:0]    req_i, we_i, gnt_o, rvalid_o;
  logic [NM*AW-1:0] addr_i;
  logic [NM*4-1:0]  be_i;
  logic [NM*32-1:0] wdata_i, rdata_o;

  logic          a_req [NM];
  logic [AW-1:0] a_addr[NM];
  logic          a_we  [NM];
  logic [3:0]    a_be  [NM];
  logic [31:0]   a_wd  [NM];

  always_comb
    for (int m = 0; m < NM; m++) begin
      req_i[m]            = a_req[m];
      addr_i[m*AW +: AW]  = a_addr[m];
      we_i[m]             = a_we[m];
      be_i[m*4 +: 4]      = a_be[m];
      wdata_i[m*32 +: 32] = a_wd[m];
    end

  spm_xbar u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .we_i(we_i),
    .be_i(be_i), .wdata_i(wdata_i), .gnt_o(gnt_o), .rvalid_o(rvalid_o),
    .rdata_o(rdata_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [31:0] model [int];
  int          q_cyc [NM][$];
  logic [31:0] q_dat [NM][$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(int row, int bank);
    return {row[8:0], bank[2:0], 2'b00};
  endfunction

  // scoreboard producer: called in the grant cycle
  task automatic note_grant(int m);
    int w;
    w = int'(a_addr[m][AW-1:2]);
    if (a_we[m]) begin
      logic [31:0] old;
      old = model.exists(w) ? model[w] : 32'h0;
      for (int i = 0; i < 4; i++)
        if (a_be[m][i]) old[8*i +: 8] = a_wd[m][8*i +: 8];
      model[w] = old;
    end else begin
      q_cyc[m].push_back(cyc + 1);
      q_dat[m].push_back(model.exists(w) ? model[w] : 32'h0);
    end
  endtask

  task automatic access(int m, logic [AW-1:0] a, logic we, logic [3:0] be, logic [31:0] d);
    a_addr[m] = a; a_we[m] = we; a_be[m] = be; a_wd[m] = d; a_req[m] = 1'b1;
    do @(negedge clk); while (!gnt_o[m]);
    note_grant(m);
    @(posedge clk); #1;
    a_req[m] = 1'b0;
  endtask

  // monitor: returned reads and per-bank grant counts
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        for (int m = 0; m < NM; m++) begin
          if (rvalid_o[m]) begin
            if (q_cyc[m].size() == 0) begin
              chk(1'b0, "R7 unexpected rvalid", 64'(m), 64'hff);
            end else begin
              int ec;
              logic [31:0] ed;
              ec = q_cyc[m].pop_front();
              ed = q_dat[m].pop_front();
              chk(ec == cyc, "R5 read latency", 64'(cyc), 64'(ec));
              chk(rdata_o[m*32 +: 32] == ed, "R5 read data", 64'(rdata_o[m*32 +: 32]), 64'(ed));
            end
          end
        end
        if (req_i != '0) begin
          bit ok;
          ok = ((gnt_o & ~req_i) == '0);
          for (int b = 0; b < 8; b++) begin
            int nr, ng;
            nr = 0; ng = 0;
            for (int m = 0; m < NM; m++)
              if (req_i[m] && a_addr[m][4:2] == 3'(b)) begin
                nr++;
                if (gnt_o[m]) ng++;
              end
            if (ng != ((nr > 0) ? 1 : 0)) ok = 1'b0;
          end
          chk(ok, "R3 per-bank grant count", 64'(gnt_o), 64'(req_i));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int m = 0; m < NM; m++) begin
      a_req[m] = 0; a_addr[m] = '0; a_we[m] = 0; a_be[m] = 0; a_wd[m] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rvalid_o == '0, "R8 rvalid in reset", 64'(rvalid_o), 64'h0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(rvalid_o == '0 && gnt_o == '0, "R8 idle after reset", 64'({rvalid_o, gnt_o}), 64'h0);

    // R1: linear fill by a core port, read back by a DMA port with offset bits set
    for (int k = 0; k < 16; k++) access(0, AW'(64 + 4*k), 1'b1, 4'hf, 32'hC0DE0000 + 32'(k));
    for (int k = 0; k < 16; k++) access(5, AW'(64 + 4*k + (k % 4)), 1'b0, 4'h0, 32'h0);

    // R1: adjacent words hit two banks, 32 bytes apart hit one
    a_addr[1] = AW'(256); a_addr[2] = AW'(260); a_we[1] = 0; a_we[2] = 0;
    a_req[1] = 1; a_req[2] = 1;
    @(negedge clk);
    chk(gnt_o == 8'b0000_0110, "R1 adjacent words parallel", 64'(gnt_o), 64'h6);
    note_grant(1); note_grant(2);
    @(posedge clk); #1;
    a_addr[2] = AW'(288);
    @(negedge clk);
    chk($countones(gnt_o) == 1, "R1 same bank serialised", 64'(gnt_o), 64'h1);
    for (int m = 1; m <= 2; m++) if (gnt_o[m]) note_grant(m);
    @(posedge clk); #1; a_req[1] = 0; a_req[2] = 0;
    repeat (2) @(posedge clk); #1;

    // R2: eight ports, eight banks, one cycle (writes then reads)
    for (int m = 0; m < NM; m++) begin
      a_addr[m] = mk(40, m); a_we[m] = 1; a_be[m] = 4'hf; a_wd[m] = 32'hB0000000 + 32'(m); a_req[m] = 1;
    end
    @(negedge clk);
    chk(gnt_o == 8'hff, "R2 all banks parallel write", 64'(gnt_o), 64'hff);
    for (int m = 0; m < NM; m++) note_grant(m);
    @(posedge clk); #1;
    for (int m = 0; m < NM; m++) begin a_addr[m] = mk(40, (m + 3) % 8); a_we[m] = 0; end
    @(negedge clk);
    chk(gnt_o == 8'hff, "R2 all banks parallel read", 64'(gnt_o), 64'hff);
    for (int m = 0; m < NM; m++) note_grant(m);
    @(posedge clk); #1;
    for (int m = 0; m < NM; m++) a_req[m] = 0;
    repeat (2) @(posedge clk); #1;

    // R4: last winner on bank 3 is port 6, then all eight pile onto bank 3
    access(6, mk(1, 3), 1'b1, 4'hf, 32'h66666666);
    for (int m = 0; m < NM; m++) begin
      a_addr[m] = mk(10 + m, 3); a_we[m] = 1; a_be[m] = 4'hf; a_wd[m] = 32'hD0D00000 + 32'(m); a_req[m] = 1;
    end
    for (int k = 0; k < NM; k++) begin
      int e;
      e = (7 + k) % 8;
      @(negedge clk);
      chk(gnt_o == 8'(1 << e), "R4 round-robin order", 64'(gnt_o), 64'(1 << e));
      note_grant(e);
      @(posedge clk); #1;
      a_req[e] = 0;
    end
    fork
      for (int k = 0; k < 4; k++) access(2, mk(10 + k, 3), 1'b0, 4'h0, 32'h0);
      for (int k = 4; k < 8; k++) access(7, mk(10 + k, 3), 1'b0, 4'h0, 32'h0);
    join

    // R6: partial writes, R3/R7: contention of a core and a DMA port
    access(3, mk(7, 5), 1'b1, 4'hf, 32'hAABBCCDD);
    access(3, mk(7, 5), 1'b1, 4'b0101, 32'h11223344);
    access(4, mk(7, 5), 1'b0, 4'h0, 32'h0);
    access(4, mk(7, 5), 1'b1, 4'b1000, 32'h5A000000);
    access(3, mk(7, 5), 1'b0, 4'h0, 32'h0);
    @(posedge clk); #1;
    chk(model[int'(mk(7, 5) >> 2)] == 32'h5A22CC44, "R6 byte-strobe model", 64'(model[int'(mk(7, 5) >> 2)]), 64'h5A22CC44);
    fork
      for (int k = 0; k < 6; k++) access(1, mk(20 + k, 5), 1'b1, 4'hf, 32'h10000000 + 32'(k));
      for (int k = 0; k < 6; k++) access(4, mk(30 + k, 5), 1'b1, 4'hf, 32'h40000000 + 32'(k));
    join
    fork
      for (int k = 0; k < 6; k++) access(4, mk(20 + k, 5), 1'b0, 4'h0, 32'h0);
      for (int k = 0; k < 6; k++) access(1, mk(30 + k, 5), 1'b0, 4'h0, 32'h0);
    join
    repeat (3) @(posedge clk);
    @(negedge clk);
    begin
      int left;
      left = 0;
      for (int m = 0; m < NM; m++) left += q_cyc[m].size();
      chk(left == 0, "R5 every read returned", 64'(left), 64'h0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule